// File: doc/BRIEF.md
# Floating-Point Square Root by Hyperbolic CORDIC

This unit takes one positive, normalized single-precision word and returns its square root as another single-precision word. It uses only integer arithmetic. Masks split the word into its biased exponent and its fraction. The lowest exponent bit decides whether the significand is used as is, in [1,2), or doubled, in [2,4), so that the exponent left over is even and halves exactly. The range-adjusted significand M seeds a hyperbolic CORDIC run in vectoring mode, with x = M + 1 and y = M - 1. This run drives y to zero and leaves x proportional to 2·sqrt(M). A single multiply by a fixed constant followed by a right shift of 23 removes both the CORDIC gain and that factor of two. The result is normalized and packed with the halved exponent. The fraction is truncated and never rounded.

The unit is iterative and performs one micro-rotation per clock. It works on one operand at a time. Operands enter on a valid/ready handshake. An operand is taken on the rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high only when the unit is idle. Results leave on a second valid/ready handshake. Once `out_valid` is raised, `out_data` holds steady until the edge where `out_ready` is seen high. The unit accepts nothing new until that result has been taken, so back-pressure on the output stalls the input side directly. `busy` is a plain status pin that is high while a computation is under way.

Top module: `fsqrt_cordic`

## Requirements
- R1: The result exponent field is within one of (E + 127) >> 1, where E is the operand's biased exponent in bits 30:23. The normalization step chooses between the three values.
- R2: An operand with bit 23 set (odd biased exponent) uses its significand 1.f directly. An operand with bit 23 clear uses 2·1.f. Both cases meet R3.
- R3: For every normalized positive operand, the decoded result differs from the exact square root by a relative error of at most 3.0e-7.
- R4: Bit 31 of every result is 0.
- R5: With the default parameters (28 as the last shift index, with shift indices 4 and 13 each used twice), a computation takes 30 micro-rotations. `out_valid` rises on the 31st rising edge after the edge that accepted the operand.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R7: While a computation is running or a result is waiting, `in_ready` is low, and any word offered on `in_valid` and `in_data` is ignored. It produces no result and does not disturb the result in progress.
- R8: After reset, `in_ready` is 1, `out_valid` is 0 and `busy` is 0.
- R9: Boundary significands meet R3 and are normalized correctly. This covers an exact 1.0, where the scaled CORDIC output may fall just below one, and the largest value just below 4.0, where it may reach two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit idle, operand will be taken |
| in_data | input | 32 | Single-precision operand (positive, normalized) |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Single-precision square root, truncated |
| busy | output | 1 | Micro-rotations or scaling under way |

## Verification
The bench sweeps every biased exponent from 1 to 254, each with a pseudo-random fraction. This catches a design that picks the wrong significand range for odd or even exponents, or that halves the exponent wrongly: such a design would be off by a factor near √2 or 2. Exact powers of four and significands just below 4.0 are aimed at the normalization step. A design that assumes the scaled value always has its leading one in the same place would return results about half or twice the true value there. The output is stalled at random to expose a result that changes or is dropped under back-pressure. While the unit is busy, junk operands are offered; a design that accepted them would emit an extra result that the scoreboard rejects.

// File: rtl/fsqrt_pkg.sv
package fsqrt_pkg;
  localparam int EXP_W    = 8;
  localparam int FRAC_W   = 23;
  localparam int EXP_BIAS = 127;

  // Gain removal: 2^26 / (2 * K_hyp), applied as (x * K) >> 23
  localparam int GAIN_W     = 26;
  localparam int GAIN_SHIFT = 23;
  localparam logic [GAIN_W-1:0] GAIN_K = 26'd40516878;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ROT,
    PH_SCALE,
    PH_HOLD
  } phase_e;

  // Shift index of micro-rotation k: 1,2,3,4,4,5,...,13,13,14,...
  function automatic int shift_of(input int k);
    if (k < 4)       return k + 1;
    else if (k < 14) return k;
    else             return k - 1;
  endfunction
endpackage

// File: rtl/fsqrt_unpack.sv
module fsqrt_unpack
  import fsqrt_pkg::*;
#(
  parameter int GUARD = 3
) (
  input  logic [30:0]                  word,
  output logic signed [FRAC_W+GUARD+4:0] x_seed,
  output logic signed [FRAC_W+GUARD+4:0] y_seed,
  output logic [EXP_W:0]               exp_half
);
  localparam int F = FRAC_W + GUARD;
  localparam int W = F + 5;

  logic [FRAC_W:0] sig;
  logic [W-1:0]    mant;
  logic [W-1:0]    one_fix;

  assign sig     = {1'b1, word[FRAC_W-1:0]};
  assign one_fix = W'(1) << F;

  // Odd biased exponent: significand in [1,2); even: doubled into [2,4)
  assign mant = word[FRAC_W] ? (W'(sig) << GUARD) : (W'(sig) << (GUARD + 1));

  assign x_seed   = $signed(mant + one_fix);
  assign y_seed   = $signed(mant - one_fix);
  assign exp_half = ({1'b0, word[30:FRAC_W]} + (EXP_W+1)'(EXP_BIAS)) >> 1;
endmodule

// File: rtl/fsqrt_rotate.sv
module fsqrt_rotate #(
  parameter int W    = 31,
  parameter int SH_W = 5
) (
  input  logic signed [W-1:0] x_in,
  input  logic signed [W-1:0] y_in,
  input  logic [SH_W-1:0]     sh,
  output logic signed [W-1:0] x_out,
  output logic signed [W-1:0] y_out
);
  logic signed [W-1:0] xs, ys;

  assign xs = x_in >>> sh;
  assign ys = y_in >>> sh;

  // Hyperbolic vectoring: rotate so that y moves towards zero
  always_comb begin
    if (!y_in[W-1]) begin
      x_out = x_in - ys;
      y_out = y_in - xs;
    end else begin
      x_out = x_in + ys;
      y_out = y_in + xs;
    end
  end
endmodule

// File: rtl/fsqrt_pack.sv
module fsqrt_pack
  import fsqrt_pkg::*;
#(
  parameter int F = 26,
  parameter int W = 31
) (
  input  logic signed [W-1:0] x_fin,
  input  logic [EXP_W:0]      exp_half,
  output logic [31:0]         word
);
  localparam int PW = W + GAIN_W;
  localparam int RW = F + 5;

  logic [PW-1:0]     prod;
  logic [RW-1:0]     r;
  logic [EXP_W:0]    e_out;
  logic [FRAC_W-1:0] frac;

  assign prod = PW'($unsigned(x_fin)) * PW'(GAIN_K);
  assign r    = RW'(prod >> GAIN_SHIFT);

  // Nominal leading one at F+3; CORDIC error can move it by one place
  always_comb begin
    if (r[F+4]) begin
      e_out = exp_half + 1'b1;
      frac  = FRAC_W'(r >> (F - 19));
    end else if (r[F+3]) begin
      e_out = exp_half;
      frac  = FRAC_W'(r >> (F - 20));
    end else begin
      e_out = exp_half - 1'b1;
      frac  = FRAC_W'(r >> (F - 21));
    end
  end

  assign word = {1'b0, EXP_W'(e_out), frac};
endmodule

// File: rtl/fsqrt_cordic.sv
module fsqrt_cordic
  import fsqrt_pkg::*;
#(
  parameter int GUARD = 3,
  parameter int LAST  = 28   // last shift index, must be at least 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic        busy
);
  localparam int F     = FRAC_W + GUARD;
  localparam int W     = F + 5;
  localparam int NITER = LAST + 2;
  localparam int CW    = $clog2(NITER);
  localparam int SH_W  = $clog2(LAST + 1);

  phase_e              phase;
  logic signed [W-1:0] x_q, y_q, x_seed, y_seed, x_nx, y_nx;
  logic [EXP_W:0]      exp_q, exp_seed;
  logic [CW-1:0]       k_q;
  logic [SH_W-1:0]     sh;
  logic [31:0]         res_q, res_nx;

  fsqrt_unpack #(.GUARD(GUARD)) u_unpack (
    .word    (in_data[30:0]),
    .x_seed  (x_seed),
    .y_seed  (y_seed),
    .exp_half(exp_seed)
  );

  assign sh = SH_W'(shift_of(int'(k_q)));

  fsqrt_rotate #(.W(W), .SH_W(SH_W)) u_rot (
    .x_in (x_q),
    .y_in (y_q),
    .sh   (sh),
    .x_out(x_nx),
    .y_out(y_nx)
  );

  fsqrt_pack #(.F(F), .W(W)) u_pack (
    .x_fin   (x_q),
    .exp_half(exp_q),
    .word    (res_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      x_q   <= '0;
      y_q   <= '0;
      exp_q <= '0;
      k_q   <= '0;
      res_q <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (in_valid) begin
          x_q   <= x_seed;
          y_q   <= y_seed;
          exp_q <= exp_seed;
          k_q   <= '0;
          phase <= PH_ROT;
        end
        PH_ROT: begin
          x_q <= x_nx;
          y_q <= y_nx;
          if (k_q == CW'(NITER - 1)) phase <= PH_SCALE;
          else                       k_q   <= k_q + 1'b1;
        end
        PH_SCALE: begin
          res_q <= res_nx;
          phase <= PH_HOLD;
        end
        PH_HOLD: if (out_ready) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign in_ready  = (phase == PH_IDLE);
  assign out_valid = (phase == PH_HOLD);
  assign busy      = (phase == PH_ROT) || (phase == PH_SCALE);
  assign out_data  = res_q;
endmodule

// File: rtl/fsqrt_cordic_chk.sv
module fsqrt_cordic_chk #(
  parameter int NITER = 30
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_data,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        busy
);
  localparam int TW = $clog2(NITER + 3) + 1;

  logic [TW-1:0] since_acc;
  logic [8:0]    half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_acc <= '0;
      half_q    <= '0;
    end else if (in_valid && in_ready) begin
      since_acc <= TW'(1);
      half_q    <= ({1'b0, in_data[30:23]} + 9'd127) >> 1;
    end else if (since_acc != '0 && !out_valid) begin
      since_acc <= since_acc + 1'b1;
    end
  end

  p_exp_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({1'b0, out_data[30:23]} + 9'd1 >= half_q) &&
                  ({1'b0, out_data[30:23]} <= half_q + 9'd1));

  p_sign_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_data[31]);

  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (since_acc == TW'(NITER + 2)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_no_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || out_valid) |-> !in_ready);

  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);
endmodule

bind fsqrt_cordic fsqrt_cordic_chk #(.NITER(LAST + 2)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_data  (in_data),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .busy     (busy)
);

// File: tb/fsqrt_cordic_test.sv
module fsqrt_cordic_test;
  localparam int NITER = 30;   // R5: 28 shifts plus two repeats
  localparam real TOL  = 3.0e-7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid, busy;
  logic [31:0] out_data;

  int   checks = 0, errors = 0, cyc = 0;
  bit   stall_en = 1'b0;
  bit   done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;
  real  exp_q[$];
  int   acc_q[$];
  bit   prev_v = 1'b0;
  bit   held_pend = 1'b0;
  logic [31:0] held_w;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fsqrt_cordic uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .busy(busy)
  );

  function automatic real to_real(input logic [31:0] w);
    real m;
    m = 1.0 + real'(w[22:0]) / 8388608.0;
    return m * (2.0 ** (real'(int'(w[30:23])) - 127.0));
  endfunction

  function automatic logic [31:0] lcg();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic tally(input bit ok, input string req, input string act, input string expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %s expected %s", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Driver: offer one operand, push its expected root on acceptance
  task automatic send(input logic [31:0] w);
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_data  = w;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
    exp_q.push_back($sqrt(to_real(w)));
    acc_q.push_back(cyc);
  endtask

  // R7: offer junk while busy, it must not be taken
  task automatic offer_junk();
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_data  = 32'h3F80_0000;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      tally(!in_ready, "R7", $sformatf("in_ready=%0b", in_ready), "in_ready=0");
    end
    #1 in_valid = 1'b0;
  endtask

  // Output back-pressure pattern
  always @(posedge clk) begin
    #1;
    if (stall_en) out_ready = lcg() [5];
    else          out_ready = 1'b1;
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (held_pend) begin
        tally(out_valid && out_data == held_w, "R6",
              $sformatf("v=%0b d=%h", out_valid, out_data), $sformatf("v=1 d=%h", held_w));
        held_pend = 1'b0;
      end
      if (out_valid && !prev_v) begin
        if (acc_q.size() != 0)
          tally(cyc - acc_q[0] == NITER + 1, "R5",
                $sformatf("%0d edges", cyc - acc_q[0]), $sformatf("%0d edges", NITER + 1));
        else
          tally(1'b0, "R7", "unexpected result", "none");
      end
      if (out_valid && !out_ready) begin
        held_w    = out_data;
        held_pend = 1'b1;
      end
      if (out_valid && out_ready && exp_q.size() != 0) begin
        real e, g, rel;
        e = exp_q.pop_front();
        void'(acc_q.pop_front());
        g = to_real(out_data);
        rel = (g > e) ? (g - e) / e : (e - g) / e;
        tally(rel <= TOL, "R1,R2,R3,R9", $sformatf("%e (rel %e)", g, rel), $sformatf("%e", e));
        tally(out_data[31] == 1'b0, "R4", $sformatf("sign=%0b", out_data[31]), "sign=0");
      end
      prev_v = out_valid;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tally(1'b0, "watchdog", "timeout", "completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R8: state after reset
    tally(in_ready && !out_valid && !busy, "R8",
          $sformatf("rdy=%0b v=%0b busy=%0b", in_ready, out_valid, busy), "rdy=1 v=0 busy=0");

    // R9 boundary significands and R2 both parities
    send(32'h3F80_0000);   // 1.0
    send(32'h4080_0000);   // 4.0
    send(32'h4000_0000);   // 2.0, doubled range
    send(32'h407F_FFFF);   // just below 4.0
    send(32'h3FFF_FFFF);   // just below 2.0
    send(32'h0080_0000);   // smallest normal
    send(32'h7F7F_FFFF);   // largest normal
    send(32'h4110_0000);   // 9.0
    offer_junk();          // R7
    send(32'h5E80_0000);   // even power of two

    // Exponent sweep with random fractions
    for (int e = 1; e < 255; e++) begin
      if (e == 128) stall_en = 1'b1;
      send({1'b0, 8'(e), 23'(lcg() >> 9)});
    end
    send(32'h4F80_0000);
    offer_junk();

    while (exp_q.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule